// File: doc/BRIEF.md
# Cascadable Channel Summer and Output Formatter

This block merges the complex baseband outputs of four upconverter channels into output sample streams. Each input beat carries one 22-bit signed in-phase sample and one 22-bit signed quadrature sample per channel. A per-channel enable mask picks which channels are added. An optional 20-bit two's-complement cascade sample, one for each of I and Q, can also be added, so that the sum from an upstream device of the same kind flows into this one. The sum is formed at extended width, clipped to the signed 20-bit range, and emitted either as two's complement or as offset binary. It can leave on two parallel buses (I and Q on the same beat) or as a multiplexed stream that carries I and then Q on one bus, with a strobe marking the I beat.

Samples enter and leave through valid/ready handshakes. A beat is taken on a rising clock edge when `in_valid` and `in_ready` are both high. The format, multiplex and enable controls are captured with that beat. The output register holds one result. It stays unchanged while `out_valid` is high and `out_ready` is low. `in_ready` is high when the register is empty, or when the beat being handed off in that same cycle is the last one of the held result. This makes the block a one-deep pipeline that passes back-pressure straight upstream. In multiplexed mode one input beat yields two output beats, so the input is stalled for the extra beat.

A separate combinational decoder turns a 2-bit enable code into eight three-state group enables. Groups 2k and 2k+1 are the low and high 10-bit halves of 20-bit pin bus k. Bus 0 is the I output, bus 1 is the Q output, and buses 2 and 3 are the cascade pins when they act as outputs.

Top module: `cas_sum_fmt`

## Requirements
- R1: Each output value is the sum of the enabled channels' signed samples for that bus (I from `ch_i`, Q from `ch_q`; channel k occupies bits [22k+21:22k]). It is presented with `out_valid` high on the cycle after the input beat is accepted.
- R2: A channel whose `ch_en` bit is 0 adds zero, whatever its sample value.
- R3: With `cas_en` = 1 the signed 20-bit cascade samples are added into the I and Q sums. With `cas_en` = 0 they have no effect on the output.
- R4: A sum above 524287 is output as 524287 (0x7FFFF), and a sum below -524288 is output as -524288 (0x80000).
- R5: With `fmt_offbin` = 1 the output is offset binary: the two's-complement result with bit 19 inverted. With `fmt_offbin` = 0 it is two's complement.
- R6: With `iq_mux` = 1 one accepted beat gives two output beats on `out_data_i`: first the I result with `out_istrb` = 1, then the Q result with `out_istrb` = 0. `out_data_q` is 0 on both beats.
- R7: With `iq_mux` = 0 a beat gives one output beat, with I on `out_data_i`, Q on `out_data_q`, and `out_istrb` = 0.
- R8: While `out_valid` = 1 and `out_ready` = 0 the output data and strobe hold steady and `in_ready` is 0. No result is lost or repeated.
- R9: With `oe_tester` = 0, `oe_code[0]` drives groups 0 and 1, `oe_code[1]` drives groups 2 and 3, and groups 4 to 7 are 0.
- R10: With `oe_tester` = 1, exactly groups 2n and 2n+1 are 1, where n is the value of `oe_code`.
- R11: After reset `out_valid` and `out_istrb` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block takes the beat on this edge |
| ch_i | input | 88 | Four packed signed 22-bit I samples, channel 0 at the LSBs |
| ch_q | input | 88 | Four packed signed 22-bit Q samples |
| ch_en | input | 4 | Per-channel summing enable |
| cas_en | input | 1 | Add the cascade samples |
| cas_i | input | 20 | Cascade I sample, two's complement |
| cas_q | input | 20 | Cascade Q sample, two's complement |
| fmt_offbin | input | 1 | 1 = offset binary, 0 = two's complement |
| iq_mux | input | 1 | 1 = I then Q on one bus |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data_i | output | 20 | I result, or the multiplexed stream |
| out_data_q | output | 20 | Q result, zero in multiplexed mode |
| out_istrb | output | 1 | High on the I beat of a multiplexed pair |
| oe_code | input | 2 | Output-enable code |
| oe_tester | input | 1 | Selects the tester decode |
| oe_grp | output | 8 | Three-state enables for the 10-bit groups |

## Verification
The bench pushes sums far enough past full scale on all four channels, in both directions, that a design clipping at the wrong width or wrapping would emit a small or sign-flipped value. It places large values on disabled channels and on the cascade inputs while the cascade is off, so that leaking gating shows up as a wrong sum. Multiplexed beats are sent under random and fully stalled `out_ready`. A design that dropped the Q beat, took a new input in the middle of a pair, or let data move during a stall would break the scoreboard order or the stability checks. The decoder is swept over every code in both modes, which catches swapped buses or off-by-one group pairs.

// File: rtl/csum_pkg.sv
package csum_pkg;
  localparam int unsigned OE_GROUPS = 8;
  localparam int unsigned OE_CODE_W = 2;

  typedef enum logic {
    PH_I = 1'b0,
    PH_Q = 1'b1
  } beat_ph_e;
endpackage

// File: rtl/csum_adder.sv
module csum_adder #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 22,
  parameter int unsigned OW  = 20
) (
  input  logic [NCH*CW-1:0] samp,
  input  logic [NCH-1:0]    en,
  input  logic              cas_en,
  input  logic [OW-1:0]     cas,
  output logic [OW-1:0]     res
);
  localparam int unsigned SW = CW + $clog2(NCH + 1) + 1;
  localparam logic signed [SW-1:0] MAXV = {{(SW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic signed [SW-1:0] term [NCH];
  logic signed [SW-1:0] acc;

  for (genvar g = 0; g < NCH; g++) begin : g_term
    logic [CW-1:0] s;
    assign s = samp[g*CW +: CW];
    assign term[g] = en[g] ? {{(SW-CW){s[CW-1]}}, s} : '0;
  end

  always_comb begin
    acc = cas_en ? {{(SW-OW){cas[OW-1]}}, cas} : '0;
    for (int k = 0; k < NCH; k++) acc = acc + term[k];
  end

  always_comb begin
    if (acc > MAXV)      res = MAXV[OW-1:0];
    else if (acc < MINV) res = MINV[OW-1:0];
    else                 res = acc[OW-1:0];
  end
endmodule

// File: rtl/csum_fmt.sv
module csum_fmt #(
  parameter int unsigned OW = 20
) (
  input  logic [OW-1:0] d,
  input  logic          offbin,
  output logic [OW-1:0] q
);
  assign q = {d[OW-1] ^ offbin, d[OW-2:0]};
endmodule

// File: rtl/csum_oe_decode.sv
module csum_oe_decode
  import csum_pkg::*;
(
  input  logic [OE_CODE_W-1:0] code,
  input  logic                 tester,
  output logic [OE_GROUPS-1:0] grp
);
  for (genvar g = 0; g < OE_GROUPS; g++) begin : g_grp
    localparam int unsigned BUS = g / 2;
    if (BUS < OE_CODE_W) begin : g_norm
      assign grp[g] = tester ? (code == OE_CODE_W'(BUS)) : code[BUS];
    end else begin : g_tonly
      assign grp[g] = tester && (code == OE_CODE_W'(BUS));
    end
  end

  always_comb begin
    if (!$isunknown({code, tester})) begin
      if (tester)
        assert_oe_tester_R10: assert ($countones(grp) == 2);
      else
        assert_oe_normal_R9: assert (grp[OE_GROUPS-1:4] == '0);
    end
  end
endmodule

// File: rtl/cas_sum_fmt.sv
module cas_sum_fmt
  import csum_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 22,
  parameter int unsigned OW  = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NCH*CW-1:0]    ch_i,
  input  logic [NCH*CW-1:0]    ch_q,
  input  logic [NCH-1:0]       ch_en,
  input  logic                 cas_en,
  input  logic [OW-1:0]        cas_i,
  input  logic [OW-1:0]        cas_q,
  input  logic                 fmt_offbin,
  input  logic                 iq_mux,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [OW-1:0]        out_data_i,
  output logic [OW-1:0]        out_data_q,
  output logic                 out_istrb,
  input  logic [OE_CODE_W-1:0] oe_code,
  input  logic                 oe_tester,
  output logic [OE_GROUPS-1:0] oe_grp
);
  logic [OW-1:0] sum_i, sum_q, fmt_i, fmt_q;
  logic [OW-1:0] hold_i, hold_q;
  logic          hold_v, mux_h, last_beat, take;
  beat_ph_e      ph;

  csum_adder #(.NCH(NCH), .CW(CW), .OW(OW)) u_add_i (
    .samp(ch_i), .en(ch_en), .cas_en(cas_en), .cas(cas_i), .res(sum_i));
  csum_adder #(.NCH(NCH), .CW(CW), .OW(OW)) u_add_q (
    .samp(ch_q), .en(ch_en), .cas_en(cas_en), .cas(cas_q), .res(sum_q));

  csum_fmt #(.OW(OW)) u_fmt_i (.d(sum_i), .offbin(fmt_offbin), .q(fmt_i));
  csum_fmt #(.OW(OW)) u_fmt_q (.d(sum_q), .offbin(fmt_offbin), .q(fmt_q));

  csum_oe_decode u_oe (.code(oe_code), .tester(oe_tester), .grp(oe_grp));

  assign last_beat = !mux_h || (ph == PH_Q);
  assign in_ready  = !hold_v || (out_ready && last_beat);
  assign take      = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      mux_h  <= 1'b0;
      ph     <= PH_I;
      hold_i <= '0;
      hold_q <= '0;
    end else if (take) begin
      hold_v <= 1'b1;
      mux_h  <= iq_mux;
      ph     <= PH_I;
      hold_i <= fmt_i;
      hold_q <= fmt_q;
    end else if (hold_v && out_ready) begin
      if (last_beat) hold_v <= 1'b0;
      else           ph     <= PH_Q;
    end
  end

  assign out_valid  = hold_v;
  assign out_data_i = (mux_h && ph == PH_Q) ? hold_q : hold_i;
  assign out_data_q = mux_h ? '0 : hold_q;
  assign out_istrb  = hold_v && mux_h && (ph == PH_I);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data_i) &&
      $stable(out_data_q) && $stable(out_istrb));

  assert_istrb_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_istrb |-> out_valid);

  assert_q_follows_i_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_istrb && out_ready |=> out_valid && !out_istrb);

  assert_no_take_midpair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_istrb |-> !in_ready);

  assert_result_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: tb/cas_sum_fmt_test.sv
module cas_sum_fmt_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [87:0]  ch_i = '0, ch_q = '0;
  logic [3:0]   ch_en = '0;
  logic         cas_en = 1'b0;
  logic [19:0]  cas_i = '0, cas_q = '0;
  logic         fmt_offbin = 1'b0, iq_mux = 1'b0;
  logic         out_valid, out_ready = 1'b0;
  logic [19:0]  out_data_i, out_data_q;
  logic         out_istrb;
  logic [1:0]   oe_code = '0;
  logic         oe_tester = 1'b0;
  logic [7:0]   oe_grp;

  int checks = 0, fails = 0;
  int rdy_mode = 0;

  typedef struct {
    logic [19:0] i;
    logic [19:0] q;
    logic        st;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  cas_sum_fmt uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .ch_i(ch_i), .ch_q(ch_q), .ch_en(ch_en), .cas_en(cas_en),
    .cas_i(cas_i), .cas_q(cas_q), .fmt_offbin(fmt_offbin), .iq_mux(iq_mux),
    .out_valid(out_valid), .out_ready(out_ready), .out_data_i(out_data_i),
    .out_data_q(out_data_q), .out_istrb(out_istrb), .oe_code(oe_code),
    .oe_tester(oe_tester), .oe_grp(oe_grp));

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [87:0] pack4(input int a, input int b, input int c, input int d);
    return {d[21:0], c[21:0], b[21:0], a[21:0]};
  endfunction

  function automatic logic [19:0] model(input logic [87:0] v, input logic [3:0] en,
                                        input logic ce, input logic [19:0] cv,
                                        input logic ob);
    longint acc = 0;
    logic [19:0] r;
    for (int k = 0; k < 4; k++)
      if (en[k]) acc += longint'($signed(v[k*22 +: 22]));
    if (ce) acc += longint'($signed(cv));
    if (acc > 524287) acc = 524287;
    if (acc < -524288) acc = -524288;
    r = acc[19:0];
    if (ob) r[19] = ~r[19];
    return r;
  endfunction

  // driver: called at a falling edge
  task automatic send(input logic [87:0] vi, input logic [87:0] vq, input logic [3:0] en,
                      input logic ce, input logic [19:0] ci, input logic [19:0] cq,
                      input logic ob, input logic mx, input string tag);
    logic [19:0] ei, eq;
    ch_i = vi; ch_q = vq; ch_en = en; cas_en = ce; cas_i = ci; cas_q = cq;
    fmt_offbin = ob; iq_mux = mx; in_valid = 1'b1;
    ei = model(vi, en, ce, ci, ob);
    eq = model(vq, en, ce, cq, ob);
    forever begin
      #1;
      if (in_ready) begin
        if (mx) begin
          sbq.push_back('{i: ei, q: 20'd0, st: 1'b1, tag: tag});
          sbq.push_back('{i: eq, q: 20'd0, st: 1'b0, tag: tag});
        end else begin
          sbq.push_back('{i: ei, q: eq, st: 1'b0, tag: tag});
        end
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (sbq.size() != 0 && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(sbq.size() == 0, "R8", "scoreboard drained", 40'(sbq.size()), 40'd0);
  endtask

  // monitor: drives out_ready and pops the scoreboard
  initial begin
    logic [7:0]  lfsr = 8'hA5;
    logic [40:0] prev = '0;
    bit          have_prev = 0;
    exp_t        e;
    forever begin
      @(negedge clk);
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = lfsr[0] | lfsr[3];
        default: out_ready = 1'b0;
      endcase
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      #2;
      if (rst_n) begin
        if (rdy_mode == 2 && out_valid) begin
          if (have_prev)
            check({out_data_i, out_data_q, out_istrb} == prev, "R8", "stall stability",
                  40'({out_data_i, out_data_q}), 40'(prev[40:1]));
          check(in_ready == 1'b0, "R8", "in_ready during stall", 40'(in_ready), 40'd0);
          prev = {out_data_i, out_data_q, out_istrb};
          have_prev = 1;
        end else begin
          have_prev = 0;
        end
        if (out_valid && out_ready) begin
          if (sbq.size() == 0) begin
            check(1'b0, "R8", "unexpected output beat", 40'(out_data_i), 40'd0);
          end else begin
            e = sbq.pop_front();
            check(out_data_i == e.i, e.tag, "out_data_i", 40'(out_data_i), 40'(e.i));
            check(out_data_q == e.q, e.tag, "out_data_q", 40'(out_data_q), 40'(e.q));
            check(out_istrb == e.st, e.tag, "out_istrb", 40'(out_istrb), 40'(e.st));
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] eg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(out_valid == 1'b0, "R11", "out_valid after reset", 40'(out_valid), 40'd0);
    check(out_istrb == 1'b0, "R11", "out_istrb after reset", 40'(out_istrb), 40'd0);
    check(in_ready == 1'b1, "R11", "in_ready after reset", 40'(in_ready), 40'd1);

    // R9 / R10 enable decode sweep
    for (int t = 0; t < 2; t++) begin
      for (int c = 0; c < 4; c++) begin
        oe_tester = t[0]; oe_code = c[1:0];
        #1;
        if (t == 0) begin
          eg = {4'b0, {2{c[1]}}, {2{c[0]}}};
          check(oe_grp == eg, "R9", "normal decode", 40'(oe_grp), 40'(eg));
        end else begin
          eg = 8'b11 << (2 * c);
          check(oe_grp == eg, "R10", "tester decode", 40'(oe_grp), 40'(eg));
        end
      end
    end

    // R1 R7 plain sum, two's complement, parallel buses
    send(pack4(1000, -200, 3000, 7), pack4(-5, -6, 100, 2000), 4'hF, 0, 20'd0, 20'd0, 0, 0, "R1 R7");
    send(pack4(-123456, 23456, 99, 1), pack4(40000, 40000, 40000, 40000), 4'hF, 0, 20'd0, 20'd0, 0, 0, "R1");
    // R2 disabled channels carry large values
    send(pack4(11, 2000000, 33, -2000000), pack4(-1900000, 7, 1900000, 9), 4'b0101, 0, 20'd0, 20'd0, 0, 0, "R2");
    send(pack4(1500000, 1500000, 1500000, 1500000), pack4(5, 5, 5, 5), 4'b0000, 0, 20'd0, 20'd0, 0, 0, "R2");
    // R3 cascade on and off
    send(pack4(100, 0, 0, 0), pack4(0, 0, 0, -100), 4'hF, 1, 20'h7FFF0, 20'h80100, 0, 0, "R3");
    send(pack4(100, 0, 0, 0), pack4(0, 0, 0, -100), 4'hF, 0, 20'h7FFF0, 20'h80100, 0, 0, "R3");
    // R4 saturation both directions
    send(pack4(1048576, 1048576, 1048576, 1048576), pack4(-2097152, -2097152, -2097152, -2097152),
         4'hF, 0, 20'd0, 20'd0, 0, 0, "R4");
    send(pack4(524287, 0, 0, 0), pack4(-524288, 0, 0, 0), 4'hF, 1, 20'd1, 20'hFFFFF, 0, 0, "R4");
    // R5 offset binary
    send(pack4(0, 0, 0, 0), pack4(-1, 0, 0, 0), 4'hF, 0, 20'd0, 20'd0, 1, 0, "R5");
    send(pack4(2000000, 2000000, 0, 0), pack4(-2000000, -2000000, 0, 0), 4'hF, 0, 20'd0, 20'd0, 1, 0, "R5");
    // R6 multiplexed I/Q
    send(pack4(321, 0, 0, 0), pack4(-654, 0, 0, 0), 4'hF, 0, 20'd0, 20'd0, 0, 1, "R6");
    send(pack4(3000, 3000, 0, 0), pack4(70, 0, 0, 0), 4'hF, 1, 20'd5, 20'd9, 1, 1, "R6");
    drain();

    // R8 random back-pressure with mixed modes
    rdy_mode = 1;
    for (int k = 0; k < 24; k++) begin
      send(pack4(k * 37001 - 400000, k * 91003, -k * 51234, 77 * k),
           pack4(k * 12345, -k * 60000, 300000 - k * 20000, k),
           k[3:0] ^ 4'b1010, k[0], 20'(k * 30011), 20'(-k * 17),
           k[2], k[1], "R8");
    end
    rdy_mode = 0;
    drain();

    // R8 full stall on a multiplexed pair
    rdy_mode = 2;
    @(negedge clk);
    send(pack4(4444, 0, 0, 0), pack4(-3333, 0, 0, 0), 4'hF, 0, 20'd0, 20'd0, 0, 1, "R8");
    repeat (4) @(negedge clk);
    rdy_mode = 0;
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule